// File: doc/BRIEF.md
# Second-Operand Shifter and Extender

This combinational unit turns a register value, or a short immediate, into the second operand of an integer ALU. One mode input picks the source. The shifted-register path moves the value left or right, logically or arithmetically, or rotates it, by an immediate amount. The extended-register path takes a byte, halfword, word or doubleword field from the low end of the value. It widens that field with zeros or with its sign, then moves it left by up to four places. The immediate path places a 12-bit constant either at bit 0 or at bit 12.

A size input selects a 32-bit or a 64-bit operation. In 32-bit operation only the low word of the source counts, the sign of a value is taken from bit 31, and the upper half of the result is held at zero. Some input combinations have no defined meaning. For these the unit raises a flag and drives a zero operand, so the decode stage can trap on the flag.

Top module: `operand_prep`

## Requirements
- R1: In shifted mode (`op_mode`=00), shift kind 00 moves the value left and kind 01 moves it right. Zeros fill the vacated positions of the selected width.
- R2: In shifted mode, kind 10 is an arithmetic right shift. It fills with the sign bit of the selected width: bit 63 when `wide`=1, bit 31 when `wide`=0.
- R3: In shifted mode, kind 11 rotates right. The low `op_amt` bits reappear at the top of the selected width.
- R4: In shifted mode, an amount of 0 returns the source unchanged (restricted to the selected width) for every shift kind.
- R5: In extended mode (`op_mode`=01), kinds 000, 001 and 010 keep the low 8, 16 or 32 bits and clear the rest.
- R6: In extended mode, kinds 100, 101 and 110 copy bit 7, 15 or 31 into every higher bit of the selected width.
- R7: In extended mode, kinds 011 and 111 pass the selected width of the source through unchanged.
- R8: In extended mode, the widened field is shifted left by `op_amt` (0 to 4) and truncated to the selected width.
- R9: In immediate mode (`op_mode`=10), the result is `imm_val` placed at bit 0 when `imm_hi`=0 and at bit 12 when `imm_hi`=1. The source, kind and amount inputs have no effect.
- R10: When `wide`=0, bits 63:32 of `operand` are always zero.
- R11: `bad_input` is 1 for mode 11, for shifted mode with `wide`=0 and `op_amt`>=32, and for extended mode with `op_amt`>4. While it is 1, `operand` is zero. In every other case it is 0, including a 64-bit shift by 32 to 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_val | input | 64 | Register value to shift or extend |
| op_mode | input | 2 | 00 shifted, 01 extended, 10 immediate, 11 undefined |
| op_kind | input | 3 | Shift kind in bits 1:0 (shifted mode) or extend kind (extended mode) |
| op_amt | input | 6 | Shift amount, or post-extend left shift |
| wide | input | 1 | 1 selects 64-bit operation, 0 selects 32-bit |
| imm_val | input | IMM_W | Immediate constant |
| imm_hi | input | 1 | Places the immediate at bit IMM_HI_SHIFT |
| operand | output | 64 | Prepared second operand |
| bad_input | output | 1 | Illegal input combination |

## Verification
The hardest cases to reach are those where the sign or the rotated bits must come from bit 31 while the upper word of the source holds contrary data. Only the 32-bit paths expose bugs that take width from the full 64-bit value.

The stimulus uses sources whose halves differ in sign and pattern, such as a negative low word under a positive upper word and the reverse. It then sweeps every 32-bit and 64-bit rotate amount against a model built from a doubled copy of the word. The legality limits are driven right at their edges: amount 31 against 32 in 32-bit mode, extend shift 4 against 5, and a 64-bit shift by 32.

// File: rtl/operand_prep.sv
module operand_prep #(
  parameter int IMM_W        = 12,
  parameter int IMM_HI_SHIFT = 12
) (
  input  logic [63:0]      src_val,
  input  logic [1:0]       op_mode,
  input  logic [2:0]       op_kind,
  input  logic [5:0]       op_amt,
  input  logic             wide,
  input  logic [IMM_W-1:0] imm_val,
  input  logic             imm_hi,
  output logic [63:0]      operand,
  output logic             bad_input
);

  localparam logic [1:0] M_SHF = 2'b00;
  localparam logic [1:0] M_EXT = 2'b01;
  localparam logic [1:0] M_IMM = 2'b10;
  localparam int         PAD_W = 64 - IMM_W;

  logic [31:0] lo;
  logic [4:0]  amt5;
  logic [63:0] shf64, ext_f, ext_s, imm_op, pick;
  logic [31:0] shf32;

  assign lo   = src_val[31:0];
  assign amt5 = op_amt[4:0];

  always_comb begin
    case (op_kind[1:0])
      2'b00:   shf64 = src_val << op_amt;
      2'b01:   shf64 = src_val >> op_amt;
      2'b10:   shf64 = $signed(src_val) >>> op_amt;
      default: shf64 = (src_val >> op_amt) | (src_val << (7'd64 - {1'b0, op_amt}));
    endcase
    case (op_kind[1:0])
      2'b00:   shf32 = lo << amt5;
      2'b01:   shf32 = lo >> amt5;
      2'b10:   shf32 = $signed(lo) >>> amt5;
      default: shf32 = (lo >> amt5) | (lo << (6'd32 - {1'b0, amt5}));
    endcase

    case (op_kind[1:0])
      2'b00:   ext_f = {{56{op_kind[2] & src_val[7]}},  src_val[7:0]};
      2'b01:   ext_f = {{48{op_kind[2] & src_val[15]}}, src_val[15:0]};
      2'b10:   ext_f = {{32{op_kind[2] & src_val[31]}}, src_val[31:0]};
      default: ext_f = src_val;
    endcase
    ext_s  = ext_f << op_amt[2:0];
    imm_op = {{PAD_W{1'b0}}, imm_val} << (imm_hi ? IMM_HI_SHIFT : 0);

    bad_input = (op_mode == 2'b11)
              | ((op_mode == M_SHF) & ~wide & op_amt[5])
              | ((op_mode == M_EXT) & (op_amt > 6'd4));

    case (op_mode)
      M_SHF:   pick = wide ? shf64 : {32'b0, shf32};
      M_EXT:   pick = ext_s;
      M_IMM:   pick = imm_op;
      default: pick = '0;
    endcase

    if (bad_input)  operand = '0;
    else if (!wide) operand = {32'b0, pick[31:0]};
    else            operand = pick;

    if (!$isunknown({src_val, op_mode, op_kind, op_amt, wide, imm_val, imm_hi})) begin
      p_upper_zero_r10: assert (wide || operand[63:32] == 32'b0)
        else $error("narrow result has upper bits set");
      p_bad_zero_r11: assert (!bad_input || operand == 64'b0)
        else $error("illegal input produced nonzero operand");
      p_passthru_r4: assert (!(op_mode == M_SHF && op_amt == 6'd0) ||
                             operand == (wide ? src_val : {32'b0, lo}))
        else $error("zero shift altered the value");
      p_imm_low_r9: assert (!(op_mode == M_IMM && imm_hi) ||
                            operand[IMM_HI_SHIFT-1:0] == '0)
        else $error("shifted immediate has low bits set");
      p_full_ext_r7: assert (!(op_mode == M_EXT && op_kind[1:0] == 2'b11 && op_amt == 6'd0) ||
                             operand == (wide ? src_val : {32'b0, lo}))
        else $error("doubleword extend altered the value");
      p_ext_amt_r11: assert (op_mode != M_EXT || bad_input == (op_amt > 6'd4))
        else $error("extend amount legality wrong");
    end
  end

endmodule

// File: tb/tb_operand_prep.sv
module tb_operand_prep;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [63:0] src_val = '0;
  logic [1:0]  op_mode = '0;
  logic [2:0]  op_kind = '0;
  logic [5:0]  op_amt  = '0;
  logic        wide    = 1'b0;
  logic [11:0] imm_val = '0;
  logic        imm_hi  = 1'b0;
  logic [63:0] operand;
  logic        bad_input;

  operand_prep dut (
    .src_val(src_val), .op_mode(op_mode), .op_kind(op_kind), .op_amt(op_amt),
    .wide(wide), .imm_val(imm_val), .imm_hi(imm_hi),
    .operand(operand), .bad_input(bad_input)
  );

  typedef struct packed {
    logic [7:0]  rq;
    logic [1:0]  m;
    logic [2:0]  k;
    logic [5:0]  a;
    logic        w;
    logic [11:0] iv;
    logic        ih;
    logic [63:0] s;
    logic [63:0] e;
    logic        b;
  } vec_t;

  localparam logic [63:0] A = 64'hF0E1_D2C3_B4A5_9687;
  localparam logic [63:0] P = 64'hFFFF_FFFF_7000_0000;
  localparam int NV = 40;

  localparam vec_t VEC [NV] = '{
    // R1 left/right logical shifts
    '{8'd1, 2'b00, 3'b000, 6'd4,  1'b1, 12'h0, 1'b0, A, 64'h0E1D_2C3B_4A59_6870, 1'b0},
    '{8'd1, 2'b00, 3'b001, 6'd8,  1'b1, 12'h0, 1'b0, A, 64'h00F0_E1D2_C3B4_A596, 1'b0},
    '{8'd1, 2'b00, 3'b000, 6'd4,  1'b0, 12'h0, 1'b0, A, 64'h0000_0000_4A59_6870, 1'b0},
    '{8'd1, 2'b00, 3'b001, 6'd4,  1'b0, 12'h0, 1'b0, A, 64'h0000_0000_0B4A_5968, 1'b0},
    '{8'd1, 2'b00, 3'b000, 6'd32, 1'b1, 12'h0, 1'b0, A, 64'hB4A5_9687_0000_0000, 1'b0},
    '{8'd1, 2'b00, 3'b001, 6'd63, 1'b1, 12'h0, 1'b0, A, 64'h0000_0000_0000_0001, 1'b0},
    // R2 arithmetic right shift
    '{8'd2, 2'b00, 3'b010, 6'd8,  1'b1, 12'h0, 1'b0, A, 64'hFFF0_E1D2_C3B4_A596, 1'b0},
    '{8'd2, 2'b00, 3'b010, 6'd4,  1'b0, 12'h0, 1'b0, A, 64'h0000_0000_FB4A_5968, 1'b0},
    '{8'd2, 2'b00, 3'b010, 6'd4,  1'b0, 12'h0, 1'b0, P, 64'h0000_0000_0700_0000, 1'b0},
    // R3 rotate right
    '{8'd3, 2'b00, 3'b011, 6'd16, 1'b1, 12'h0, 1'b0, A, 64'h9687_F0E1_D2C3_B4A5, 1'b0},
    '{8'd3, 2'b00, 3'b011, 6'd8,  1'b0, 12'h0, 1'b0, A, 64'h0000_0000_87B4_A596, 1'b0},
    // R4 zero amount
    '{8'd4, 2'b00, 3'b011, 6'd0,  1'b1, 12'h0, 1'b0, A, A,                     1'b0},
    '{8'd4, 2'b00, 3'b010, 6'd0,  1'b0, 12'h0, 1'b0, A, 64'h0000_0000_B4A5_9687, 1'b0},
    '{8'd4, 2'b00, 3'b001, 6'd0,  1'b1, 12'h0, 1'b0, A, A,                     1'b0},
    '{8'd4, 2'b00, 3'b000, 6'd0,  1'b0, 12'h0, 1'b0, A, 64'h0000_0000_B4A5_9687, 1'b0},
    // R5 zero extension
    '{8'd5, 2'b01, 3'b000, 6'd0,  1'b1, 12'h0, 1'b0, A, 64'h0000_0000_0000_0087, 1'b0},
    '{8'd5, 2'b01, 3'b001, 6'd0,  1'b1, 12'h0, 1'b0, A, 64'h0000_0000_0000_9687, 1'b0},
    '{8'd5, 2'b01, 3'b010, 6'd0,  1'b1, 12'h0, 1'b0, A, 64'h0000_0000_B4A5_9687, 1'b0},
    // R6 sign extension
    '{8'd6, 2'b01, 3'b100, 6'd0,  1'b1, 12'h0, 1'b0, A, 64'hFFFF_FFFF_FFFF_FF87, 1'b0},
    '{8'd6, 2'b01, 3'b101, 6'd0,  1'b1, 12'h0, 1'b0, A, 64'hFFFF_FFFF_FFFF_9687, 1'b0},
    '{8'd6, 2'b01, 3'b110, 6'd0,  1'b1, 12'h0, 1'b0, A, 64'hFFFF_FFFF_B4A5_9687, 1'b0},
    '{8'd6, 2'b01, 3'b100, 6'd0,  1'b0, 12'h0, 1'b0, A, 64'h0000_0000_FFFF_FF87, 1'b0},
    '{8'd6, 2'b01, 3'b110, 6'd0,  1'b0, 12'h0, 1'b0, A, 64'h0000_0000_B4A5_9687, 1'b0},
    '{8'd6, 2'b01, 3'b110, 6'd0,  1'b1, 12'h0, 1'b0, P, 64'h0000_0000_7000_0000, 1'b0},
    // R7 doubleword pass-through
    '{8'd7, 2'b01, 3'b011, 6'd0,  1'b1, 12'h0, 1'b0, A, A,                     1'b0},
    '{8'd7, 2'b01, 3'b111, 6'd0,  1'b1, 12'h0, 1'b0, A, A,                     1'b0},
    '{8'd7, 2'b01, 3'b011, 6'd0,  1'b0, 12'h0, 1'b0, A, 64'h0000_0000_B4A5_9687, 1'b0},
    // R8 post-extend shift
    '{8'd8, 2'b01, 3'b101, 6'd4,  1'b1, 12'h0, 1'b0, A, 64'hFFFF_FFFF_FFF9_6870, 1'b0},
    '{8'd8, 2'b01, 3'b000, 6'd3,  1'b1, 12'h0, 1'b0, A, 64'h0000_0000_0000_0438, 1'b0},
    '{8'd8, 2'b01, 3'b110, 6'd4,  1'b0, 12'h0, 1'b0, A, 64'h0000_0000_4A59_6870, 1'b0},
    '{8'd8, 2'b01, 3'b111, 6'd4,  1'b1, 12'h0, 1'b0, A, 64'h0E1D_2C3B_4A59_6870, 1'b0},
    // R9 immediate placement, other inputs ignored
    '{8'd9, 2'b10, 3'b010, 6'd33, 1'b1, 12'hABC, 1'b0, A, 64'h0000_0000_0000_0ABC, 1'b0},
    '{8'd9, 2'b10, 3'b111, 6'd9,  1'b1, 12'hABC, 1'b1, A, 64'h0000_0000_00AB_C000, 1'b0},
    '{8'd9, 2'b10, 3'b000, 6'd40, 1'b0, 12'hFFF, 1'b1, P, 64'h0000_0000_00FF_F000, 1'b0},
    // R10 narrow upper zero with negative source
    '{8'd10, 2'b00, 3'b011, 6'd31, 1'b0, 12'h0, 1'b0, A, 64'h0000_0000_694B_2D0F, 1'b0},
    // R11 illegal combinations and their edges
    '{8'd11, 2'b00, 3'b000, 6'd32, 1'b0, 12'h0, 1'b0, A, 64'h0,              1'b1},
    '{8'd11, 2'b00, 3'b001, 6'd31, 1'b0, 12'h0, 1'b0, A, 64'h0000_0000_0000_0001, 1'b0},
    '{8'd11, 2'b01, 3'b000, 6'd5,  1'b1, 12'h0, 1'b0, A, 64'h0,              1'b1},
    '{8'd11, 2'b01, 3'b000, 6'd4,  1'b1, 12'h0, 1'b0, A, 64'h0000_0000_0000_0870, 1'b0},
    '{8'd11, 2'b11, 3'b000, 6'd0,  1'b1, 12'h5, 1'b0, A, 64'h0,              1'b1}
  };

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp,
                       input logic gb, input logic eb);
    n_chk++;
    if (got !== exp || gb !== eb) begin
      n_bad++;
      $display("FAIL %s: operand=%h bad=%b expected operand=%h bad=%b", tag, got, gb, exp, eb);
    end
  endtask

  task automatic apply(input logic [1:0] m, input logic [2:0] k, input logic [5:0] a,
                       input logic w, input logic [11:0] iv, input logic ih,
                       input logic [63:0] s);
    @(posedge clk);
    op_mode = m; op_kind = k; op_amt = a; wide = w; imm_val = iv; imm_hi = ih; src_val = s;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset-state inputs (all zero) give a zero narrow operand, no flag
    check("R10 reset", operand, 64'h0, bad_input, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].m, VEC[i].k, VEC[i].a, VEC[i].w, VEC[i].iv, VEC[i].ih, VEC[i].s);
      check($sformatf("R%0d vec%0d", VEC[i].rq, i), operand, VEC[i].e, bad_input, VEC[i].b);
    end

    // R3 rotate sweep, 32-bit, against doubled-word model
    for (int a = 0; a < 32; a++) begin
      logic [63:0] dbl;
      dbl = {A[31:0], A[31:0]} >> a;
      apply(2'b00, 3'b011, 6'(a), 1'b0, 12'h0, 1'b0, A);
      check($sformatf("R3 ror32 amt %0d", a), operand, {32'b0, dbl[31:0]}, bad_input, 1'b0);
    end
    // R3 rotate sweep, 64-bit
    for (int a = 0; a < 64; a++) begin
      logic [127:0] dbl;
      dbl = {A, A} >> a;
      apply(2'b00, 3'b011, 6'(a), 1'b1, 12'h0, 1'b0, A);
      check($sformatf("R3 ror64 amt %0d", a), operand, dbl[63:0], bad_input, 1'b0);
    end
    // R11 all narrow shift amounts 32..63 flagged for every kind
    for (int a = 32; a < 64; a++) begin
      apply(2'b00, 3'(a % 4), 6'(a), 1'b0, 12'h0, 1'b0, A);
      check($sformatf("R11 narrow amt %0d", a), operand, 64'h0, bad_input, 1'b1);
    end
    // R2 sign taken from bit 31 with contrary upper word
    apply(2'b00, 3'b010, 6'd31, 1'b0, 12'h0, 1'b0, 64'h7FFF_FFFF_8000_0000);
    check("R2 asr31 narrow", operand, 64'h0000_0000_FFFF_FFFF, bad_input, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: operand=%h bad=%b expected completion", operand, bad_input);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule